// File: doc/BRIEF.md
# Logic Analyzer Trigger Capture Controller

This block is an embedded capture engine for on-chip debug. A bus of probed signals is written into a circular sample store on every clock. Recording runs before the trigger as well as after it, so the history leading up to an event is kept. One probe bit is chosen as the trigger source. When its programmed condition is met, the engine stores the remaining post-trigger samples and stops writing. It then streams the captured window out, oldest sample first.

Software programs the engine through a small register write port. It selects the trigger channel and condition, the window length, and the position of the trigger inside the window as a percentage. A start bit arms the engine. The window is split into `pre = floor(depth * pct / 100)` samples taken before the trigger sample and `post = depth - pre` samples starting with the trigger sample itself. The captured window leaves the block on a valid/ready stream, and a done output reports that the readout has finished.

Top module: `la_trig_capture`

## Requirements
- R1: After reset, `outValid` and `capDone` are both low.
- R2: Probe samples are recorded on every clock while armed and capturing. The streamed window is the `depth` consecutive samples beginning `pre` samples before the trigger sample. When `post` is 0, the trigger sample itself is not part of the window.
- R3: Register address 0 holds the trigger condition in bits [1:0] and the trigger channel in bits [6:4]. The condition encodings are 00 rising edge, 01 falling edge, 10 level high and 11 level low. An edge compares the current sample of the channel with the sample of the cycle before, including the cycle in which the start bit is written.
- R4: Register address 1 sets the depth. A written value of 0 becomes 1, and a value above `2**ADDR_W` becomes `2**ADDR_W`. Exactly `depth` samples are transferred per capture.
- R5: Register address 2 sets the trigger position in percent. A value above 100 is stored as 100. The pre-trigger count is `floor(depth*pct/100)`.
- R6: A trigger condition is ignored until at least `pre` samples have been recorded since arming. Without a qualifying trigger, no data is streamed and `capDone` stays low.
- R7: Samples leave in time order, oldest first. While `outValid` is high and `outReady` is low, `outValid` stays high and `outData` stays unchanged.
- R8: Writing 1 to bit 0 of register address 3 arms the engine from any state. In the cycle after that write, `capDone` and `outValid` are low. After the last transfer, `capDone` is high and `outValid` is low until the next arm.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| probeIn | input | PROBE_W | Probed signal bus, sampled every cycle |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgAddr | input | 2 | Configuration register address |
| cfgWrData | input | 8 | Configuration write data |
| outValid | output | 1 | Captured sample available |
| outReady | input | 1 | Consumer accepts the sample |
| outData | output | PROBE_W | Captured sample, oldest first |
| capDone | output | 1 | Readout of the window finished |

## Verification
The assertions check four things on every cycle:
- the stream holds `outValid` and `outData` during back-pressure;
- arming clears the done and valid outputs;
- done stays high until the next arm;
- the transfer count equals the active depth at the moment done rises, and the stored percentage never exceeds 100.

Some properties are visible only through the bench's sweep over trigger conditions, depths, percentages and trigger timings. These are which sample becomes the trigger, whether early triggers are correctly ignored, and whether the streamed window holds exactly the expected samples in order.

// File: rtl/la_cap_pkg.sv
package la_cap_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARMED,
    ST_POST,
    ST_READ,
    ST_DONE
  } capState_t;

  localparam logic [1:0] TRIG_RISE = 2'b00;
  localparam logic [1:0] TRIG_FALL = 2'b01;
  localparam logic [1:0] TRIG_HIGH = 2'b10;
  localparam logic [1:0] TRIG_LOW  = 2'b11;

  localparam logic [1:0] REG_TRIG  = 2'd0;
  localparam logic [1:0] REG_DEPTH = 2'd1;
  localparam logic [1:0] REG_PCT   = 2'd2;
  localparam logic [1:0] REG_CTRL  = 2'd3;

  // strobes from control to datapath
  typedef struct packed {
    logic arm;
    logic wrEn;
    logic cntEn;
    logic trigLatch;
    logic postDec;
    logic rdAdv;
  } ctrlStrobe_t;

  // conditions from datapath to control
  typedef struct packed {
    logic trigHit;
    logic postZero;
    logic postOne;
    logic postLast;
    logic rdLast;
  } dpStatus_t;

endpackage

// File: rtl/la_cfg_regs.sv
module la_cfg_regs
  import la_cap_pkg::*;
#(
  parameter int DEPTH_W   = 5,
  parameter int DEPTH_MAX = 16,
  parameter int SEL_W     = 3,
  parameter int CFG_W     = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgWrEn,
  input  logic [1:0]         cfgAddr,
  input  logic [CFG_W-1:0]   cfgWrData,
  output logic [1:0]         trigType,
  output logic [SEL_W-1:0]   trigSel,
  output logic [DEPTH_W-1:0] depthReg,
  output logic [6:0]         pctReg,
  output logic               startReq
);

  localparam int SEL_LSB = 4;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      trigType <= TRIG_RISE;
      trigSel  <= '0;
      depthReg <= DEPTH_W'(DEPTH_MAX);
      pctReg   <= 7'd50;
    end else if (cfgWrEn) begin
      case (cfgAddr)
        REG_TRIG: begin
          trigType <= cfgWrData[1:0];
          trigSel  <= cfgWrData[SEL_LSB +: SEL_W];
        end
        REG_DEPTH: begin
          if (cfgWrData == '0)
            depthReg <= DEPTH_W'(1);
          else if (cfgWrData > CFG_W'(DEPTH_MAX))
            depthReg <= DEPTH_W'(DEPTH_MAX);
          else
            depthReg <= DEPTH_W'(cfgWrData);
        end
        REG_PCT: begin
          if (cfgWrData > CFG_W'(100))
            pctReg <= 7'd100;
          else
            pctReg <= 7'(cfgWrData);
        end
        default: ;
      endcase
    end
  end

  assign startReq = cfgWrEn && (cfgAddr == REG_CTRL) && cfgWrData[0];

endmodule

// File: rtl/la_capture_ctrl.sv
module la_capture_ctrl
  import la_cap_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        startReq,
  input  logic        outReady,
  input  dpStatus_t   dpStat,
  output ctrlStrobe_t strobe,
  output logic        outValid,
  output logic        capDone
);

  capState_t state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    strobe    = '0;
    stateNext = state;
    strobe.arm = startReq;
    case (state)
      ST_IDLE: strobe.wrEn = 1'b1;
      ST_ARMED: begin
        strobe.cntEn = 1'b1;
        if (dpStat.trigHit) begin
          strobe.trigLatch = 1'b1;
          strobe.wrEn      = !dpStat.postZero;
          stateNext = (dpStat.postZero || dpStat.postOne) ? ST_READ : ST_POST;
        end else begin
          strobe.wrEn = 1'b1;
        end
      end
      ST_POST: begin
        strobe.wrEn    = 1'b1;
        strobe.postDec = 1'b1;
        if (dpStat.postLast) stateNext = ST_READ;
      end
      ST_READ: begin
        if (outReady) begin
          strobe.rdAdv = 1'b1;
          if (dpStat.rdLast) stateNext = ST_DONE;
        end
      end
      ST_DONE: ;
      default: stateNext = ST_IDLE;
    endcase
    if (startReq) stateNext = ST_ARMED;
  end

  assign outValid = (state == ST_READ);
  assign capDone  = (state == ST_DONE);

endmodule

// File: rtl/la_capture_dp.sv
module la_capture_dp
  import la_cap_pkg::*;
#(
  parameter int PROBE_W = 8,
  parameter int ADDR_W  = 4,
  parameter int DEPTH_W = ADDR_W + 1,
  parameter int SEL_W   = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobe_t        strobe,
  input  logic [PROBE_W-1:0] probeIn,
  input  logic [1:0]         cfgType,
  input  logic [SEL_W-1:0]   cfgSel,
  input  logic [DEPTH_W-1:0] cfgDepth,
  input  logic [6:0]         cfgPct,
  output dpStatus_t          dpStat,
  output logic [PROBE_W-1:0] outData,
  output logic [DEPTH_W-1:0] actDepth
);

  localparam int DEPTH_MAX = 1 << ADDR_W;
  localparam int PROD_W    = DEPTH_W + 7;

  logic [PROBE_W-1:0] mem [DEPTH_MAX];
  logic [ADDR_W-1:0]  wrPtr, rdPtr, startPtr;
  logic [DEPTH_W-1:0] armCnt, rdLeft, postLeft;
  logic [DEPTH_W-1:0] snapPre, snapPost, preCalc;
  logic [1:0]         snapType;
  logic [SEL_W-1:0]   snapSel;
  logic               trigPrev, trigCur, trigCond;
  logic [PROD_W-1:0]  prod;
  logic [DEPTH_W:0]   sumA;

  function automatic logic [ADDR_W-1:0] wrapInc(input logic [ADDR_W-1:0] p,
                                                input logic [DEPTH_W-1:0] d);
    if (DEPTH_W'(p) + DEPTH_W'(1) >= d) return '0;
    return p + ADDR_W'(1);
  endfunction

  // pre-trigger count from the holding registers
  assign prod    = PROD_W'(cfgDepth) * PROD_W'(cfgPct);
  assign preCalc = DEPTH_W'(prod / PROD_W'(100));

  // first window address: trigger address minus pre count, modulo depth
  assign sumA     = (DEPTH_W+1)'(wrPtr) + (DEPTH_W+1)'(actDepth) - (DEPTH_W+1)'(snapPre);
  assign startPtr = (sumA >= (DEPTH_W+1)'(actDepth)) ? ADDR_W'(sumA - (DEPTH_W+1)'(actDepth))
                                                      : ADDR_W'(sumA);

  assign trigCur = probeIn[snapSel];
  always_comb begin
    case (snapType)
      TRIG_RISE: trigCond = trigCur && !trigPrev;
      TRIG_FALL: trigCond = !trigCur && trigPrev;
      TRIG_HIGH: trigCond = trigCur;
      default:   trigCond = !trigCur;
    endcase
    dpStat.trigHit  = trigCond && (armCnt >= snapPre);
    dpStat.postZero = (snapPost == '0);
    dpStat.postOne  = (snapPost == DEPTH_W'(1));
    dpStat.postLast = (postLeft == DEPTH_W'(1));
    dpStat.rdLast   = (rdLeft == DEPTH_W'(1));
  end

  always_ff @(posedge clk) begin
    if (strobe.wrEn) mem[wrPtr] <= probeIn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      trigPrev <= 1'b0;
    end else begin
      trigPrev <= strobe.arm ? probeIn[cfgSel] : probeIn[snapSel];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      actDepth <= DEPTH_W'(DEPTH_MAX);
      snapPre  <= '0;
      snapPost <= DEPTH_W'(DEPTH_MAX);
      snapType <= TRIG_RISE;
      snapSel  <= '0;
      wrPtr    <= '0;
      rdPtr    <= '0;
      armCnt   <= '0;
      rdLeft   <= '0;
      postLeft <= '0;
    end else if (strobe.arm) begin
      actDepth <= cfgDepth;
      snapPre  <= preCalc;
      snapPost <= cfgDepth - preCalc;
      snapType <= cfgType;
      snapSel  <= cfgSel;
      wrPtr    <= '0;
      armCnt   <= '0;
    end else begin
      if (strobe.wrEn) wrPtr <= wrapInc(wrPtr, actDepth);
      if (strobe.wrEn && strobe.cntEn && (armCnt < actDepth))
        armCnt <= armCnt + DEPTH_W'(1);
      if (strobe.trigLatch) begin
        rdPtr    <= startPtr;
        rdLeft   <= actDepth;
        postLeft <= snapPost - DEPTH_W'(1);
      end
      if (strobe.postDec) postLeft <= postLeft - DEPTH_W'(1);
      if (strobe.rdAdv) begin
        rdPtr  <= wrapInc(rdPtr, actDepth);
        rdLeft <= rdLeft - DEPTH_W'(1);
      end
    end
  end

  assign outData = mem[rdPtr];

endmodule

// File: rtl/la_trig_capture.sv
module la_trig_capture
  import la_cap_pkg::*;
#(
  parameter int PROBE_W = 8,
  parameter int ADDR_W  = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [PROBE_W-1:0] probeIn,
  input  logic               cfgWrEn,
  input  logic [1:0]         cfgAddr,
  input  logic [7:0]         cfgWrData,
  output logic               outValid,
  input  logic               outReady,
  output logic [PROBE_W-1:0] outData,
  output logic               capDone
);

  localparam int DEPTH_W   = ADDR_W + 1;
  localparam int DEPTH_MAX = 1 << ADDR_W;
  localparam int SEL_W     = (PROBE_W > 1) ? $clog2(PROBE_W) : 1;

  logic [1:0]         cfgType;
  logic [SEL_W-1:0]   cfgSel;
  logic [DEPTH_W-1:0] cfgDepth;
  logic [6:0]         cfgPct;
  logic               startReq;
  logic [DEPTH_W-1:0] actDepth;
  ctrlStrobe_t        strobe;
  dpStatus_t          dpStat;

  la_cfg_regs #(
    .DEPTH_W(DEPTH_W), .DEPTH_MAX(DEPTH_MAX), .SEL_W(SEL_W), .CFG_W(8)
  ) regs_i (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr),
    .cfgWrData(cfgWrData), .trigType(cfgType), .trigSel(cfgSel),
    .depthReg(cfgDepth), .pctReg(cfgPct), .startReq(startReq)
  );

  la_capture_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .startReq(startReq), .outReady(outReady),
    .dpStat(dpStat), .strobe(strobe), .outValid(outValid), .capDone(capDone)
  );

  la_capture_dp #(
    .PROBE_W(PROBE_W), .ADDR_W(ADDR_W), .DEPTH_W(DEPTH_W), .SEL_W(SEL_W)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .probeIn(probeIn),
    .cfgType(cfgType), .cfgSel(cfgSel), .cfgDepth(cfgDepth), .cfgPct(cfgPct),
    .dpStat(dpStat), .outData(outData), .actDepth(actDepth)
  );

endmodule

// File: rtl/la_trig_capture_chk.sv
module la_trig_capture_chk #(
  parameter int PROBE_W = 8,
  parameter int ADDR_W  = 4
) (
  input logic               clk,
  input logic               rstN,
  input logic               outValid,
  input logic               outReady,
  input logic [PROBE_W-1:0] outData,
  input logic               capDone,
  input logic               startReq,
  input logic [ADDR_W:0]    actDepth,
  input logic [6:0]         cfgPct
);

  localparam int DEPTH_MAX = 1 << ADDR_W;

  logic [15:0] xferCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                      xferCnt <= '0;
    else if (startReq)              xferCnt <= '0;
    else if (outValid && outReady)  xferCnt <= xferCnt + 16'd1;
  end

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady && !startReq |=> outValid && $stable(outData)); // R7

  AST_ARM_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    startReq |=> !capDone && !outValid); // R8

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    capDone && !startReq |=> capDone); // R8

  AST_WINDOW_LEN: assert property (@(posedge clk) disable iff (!rstN)
    $rose(capDone) |-> xferCnt == 16'(actDepth)); // R4

  AST_DEPTH_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    actDepth >= (ADDR_W+1)'(1) && actDepth <= (ADDR_W+1)'(DEPTH_MAX)); // R4

  AST_PCT_CLAMP: assert property (@(posedge clk) disable iff (!rstN)
    cfgPct <= 7'd100); // R5

endmodule

bind la_trig_capture la_trig_capture_chk #(.PROBE_W(PROBE_W), .ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rstN(rstN), .outValid(outValid), .outReady(outReady),
  .outData(outData), .capDone(capDone), .startReq(startReq),
  .actDepth(actDepth), .cfgPct(cfgPct)
);

// File: tb/la_trig_capture_tb.sv
module la_trig_capture_tb_top;

  localparam int PROBE_W = 8;
  localparam int ADDR_W  = 4;
  localparam int DMAX    = 1 << ADDR_W;
  localparam int LEN     = 70;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [PROBE_W-1:0] probeIn = '0;
  logic cfgWrEn = 1'b0;
  logic [1:0] cfgAddr = '0;
  logic [7:0] cfgWrData = '0;
  logic outValid, outReady = 1'b0, capDone;
  logic [PROBE_W-1:0] outData;

  int checks = 0;
  int fails = 0;

  always #10 clk = ~clk;

  la_trig_capture #(.PROBE_W(PROBE_W), .ADDR_W(ADDR_W)) dut_i (
    .clk(clk), .rstN(rstN), .probeIn(probeIn), .cfgWrEn(cfgWrEn),
    .cfgAddr(cfgAddr), .cfgWrData(cfgWrData), .outValid(outValid),
    .outReady(outReady), .outData(outData), .capDone(capDone)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic bit trigBit(int k, int typ, int tg);
    if (typ == 0 || typ == 2) return (k >= tg);
    return (k < tg);
  endfunction

  // sample k of a scenario, k >= -1 (-1 is the arm cycle)
  function automatic logic [7:0] sval(int k, int typ, int sel, int tg, int seed);
    logic [7:0] v;
    v = 8'((k + 1) * 29 + seed);
    v[sel] = trigBit(k, typ, tg);
    return v;
  endfunction

  function automatic bit condMet(int typ, bit cur, bit prev);
    case (typ)
      0: return cur && !prev;
      1: return !cur && prev;
      2: return cur;
      default: return !cur;
    endcase
  endfunction

  task automatic cfgWrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgAddr = a; cfgWrData = d;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  task automatic runScenario(input int typ, input int sel, input int dRaw,
                             input int pRaw, input int tg, input int seed);
    int dEff, pEff, pre, post, t, got, stallData;
    bit stalled, sawValid;
    dEff = (dRaw == 0) ? 1 : ((dRaw > DMAX) ? DMAX : dRaw);       // R4
    pEff = (pRaw > 100) ? 100 : pRaw;                             // R5
    pre  = (dEff * pEff) / 100;
    post = dEff - pre;
    t = -1;
    for (int k = 0; k < LEN; k++) begin                          // R6: ignore before pre
      if (t < 0 && k >= pre &&
          condMet(typ, trigBit(k, typ, tg), trigBit(k - 1, typ, tg))) t = k;
    end
    cfgWrite(2'd0, 8'((sel << 4) | typ));                          // R3
    cfgWrite(2'd1, 8'(dRaw));
    cfgWrite(2'd2, 8'(pRaw));
    @(negedge clk);
    cfgWrEn = 1'b1; cfgAddr = 2'd3; cfgWrData = 8'd1;
    probeIn = sval(-1, typ, sel, tg, seed);
    outReady = 1'b0;
    got = 0; stalled = 1'b0; sawValid = 1'b0; stallData = 0;
    for (int c = 0; c < 400; c++) begin
      @(negedge clk);
      cfgWrEn = 1'b0;
      if (c == 0) chk(!capDone && !outValid, "R8 arm clears", int'(capDone), 0);
      if (t >= 0 && got == dEff) begin
        chk(capDone && !outValid, "R8 done after window", int'(capDone), 1);
        @(negedge clk);
        chk(capDone && !outValid, "R8 done holds", int'(capDone), 1);
        return;
      end
      if (t < 0 && c >= LEN) begin
        chk(!sawValid && !capDone, "R6 no trigger no data", int'(sawValid), 0);
        return;
      end
      if (stalled) begin
        chk(outValid && int'(outData) == stallData, "R7 hold while stalled",
            int'(outData), stallData);
        stalled = 1'b0;
      end
      outReady = (((c * 5) + seed) % 4) != 1;
      if (outValid) begin
        sawValid = 1'b1;
        if (t < 0) begin
          chk(1'b0, "R6 unexpected data", int'(outData), -1);
        end else if (outReady) begin
          // R2 R7: oldest first, window begins pre samples before trigger
          chk(outData == sval(t - pre + got, typ, sel, tg, seed), "R2 window sample",
              int'(outData), int'(sval(t - pre + got, typ, sel, tg, seed)));
          got++;
        end else begin
          stalled = 1'b1;
          stallData = int'(outData);
        end
      end
      probeIn = sval(c, typ, sel, tg, seed);
    end
    chk(1'b0, "R4 window never completed", got, dEff);
  endtask

  initial begin
    int depths[5];
    int pcts[5];
    int sc;
    depths = '{0, 1, 3, 16, 20};
    pcts   = '{0, 25, 50, 100, 127};
    repeat (3) @(negedge clk);
    chk(!outValid && !capDone, "R1 reset state", int'(outValid) + int'(capDone), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(!outValid && !capDone, "R1 after reset release", int'(capDone), 0);
    sc = 0;
    for (int typ = 0; typ < 4; typ++) begin
      for (int di = 0; di < 5; di++) begin
        for (int pi = 0; pi < 5; pi++) begin
          runScenario(typ, (sc * 3) % 8, depths[di], pcts[pi], (sc * 7) % 24, sc * 11);
          sc++;
        end
      end
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule